// File: doc/BRIEF.md
# Interrupt and Reset Sequencing Controller

This block sits beside a processor core's control unit. It decides, at each instruction boundary, whether the core takes an interrupt, stops in a wait, or carries on. There are two interrupt sources. The first is a non-maskable request. It is caught on its rising edge and held until the core services it, and it always carries the same type number. The second is a maskable level request. It is honoured only while the core's interrupt-enable flag is set, and it asks for an acknowledge cycle, during which the type number is obtained.

A wait instruction that ends while the test input is high parks the core. The block raises a stall output and checks the test input again on every clock. A pending interrupt also ends the wait.

The block also qualifies the system reset input. A reset that is held long enough holds the core stalled and clears every pending request. When it is released, the block gives a one-cycle load strobe together with the fixed restart address. A reset that is too short is filtered out and has no effect.

Top module: `irs_ctrl`

## Requirements
- R1: A low-to-high transition on `nmi_in` is latched and kept pending until an instruction boundary services it. Holding `nmi_in` high raises no second request. Software cannot mask it: `ie_flag` has no effect on it.
- R2: When `insn_end` is high and a non-maskable request is pending or rising in that cycle, `take_irq` is high for exactly one cycle, in the next cycle. In that cycle `irq_type` equals 2. In all other cycles `irq_type` is 0.
- R3: If both sources are active at the same boundary, the non-maskable request is serviced and `ack_req_n` stays high. The maskable request is serviced at a later boundary if it is still active then.
- R4: When `insn_end`, `intr_in` and `ie_flag` are all high and no non-maskable request is present, `ack_req_n` (active low) is low for exactly one cycle, in the next cycle, and `irq_type` is 0.
- R5: `intr_in` is ignored while `ie_flag` is low, and in any cycle where `insn_end` is low and the block is not waiting.
- R6: When `insn_end` and `wait_op` are high and `test_n` is high, `stall` rises in the next cycle. It stays high until the cycle after `test_n` is sampled low. If `test_n` is low at the boundary, `stall` does not rise.
- R7: While waiting, a non-maskable request, or a maskable request with `ie_flag` set, is serviced without waiting for `test_n`, and `stall` falls in the same cycle as the interrupt output.
- R8: When `rst_in` is high for at least 4 consecutive clock edges, `stall` is high from the cycle after the 4th edge until release. In the cycle after the first edge with `rst_in` low, `vec_load` is high for exactly one cycle. `vec_addr` is always 20'hFFFF0, which is segment FFFFh shifted left by 4 plus offset 0.
- R9: A high pulse on `rst_in` that lasts 3 or fewer edges produces no `vec_load` and no `stall`, and it keeps any pending non-maskable request.
- R10: A qualified reset clears a pending non-maskable request and ends a wait.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_in | input | 1 | Raw system reset, active high, qualified inside the block |
| nmi_in | input | 1 | Non-maskable request, rising-edge sensitive |
| intr_in | input | 1 | Maskable request, level sensitive |
| ie_flag | input | 1 | Core interrupt-enable flag |
| test_n | input | 1 | Test input polled by the wait instruction; low lets execution go on |
| insn_end | input | 1 | High in the last clock of an instruction |
| wait_op | input | 1 | The instruction ending is a wait instruction |
| take_irq | output | 1 | One-cycle strobe: take the fixed-type interrupt |
| irq_type | output | 8 | Type number that goes with `take_irq` |
| ack_req_n | output | 1 | One-cycle active-low request for an acknowledge cycle |
| stall | output | 1 | Holds the core (qualified reset or wait) |
| vec_load | output | 1 | One-cycle strobe: load the restart address |
| vec_addr | output | 20 | Restart physical address |

## Verification
Every decision is registered once. So `take_irq`, `irq_type` and `ack_req_n` respond in the cycle after the boundary edge, and `stall` enters or leaves a wait in the cycle after the edge that samples `insn_end` or `test_n`. A qualified reset raises `stall` after its 4th high edge, and `vec_load` appears after the first low edge. The bench changes inputs only on falling edges. At each falling edge it compares every output with a behavioural model that has advanced by exactly one rising edge. The directed checks read outputs one falling edge after the stimulus, which matches that one-register latency.

// File: rtl/irs_pkg.sv
package irs_pkg;

  localparam int SEG_W  = 16;
  localparam int ADDR_W = 20;

  // Boundary decision taken by the arbiter.
  typedef enum logic [1:0] {
    DEC_NONE = 2'd0,
    DEC_NMI  = 2'd1,
    DEC_ACK  = 2'd2,
    DEC_WAIT = 2'd3
  } dec_e;

  // Physical address: segment shifted left by four plus offset.
  function automatic logic [ADDR_W-1:0] phys_addr(input logic [SEG_W-1:0] seg,
                                                  input logic [SEG_W-1:0] off);
    phys_addr = {seg, 4'h0} + {4'h0, off};
  endfunction

endpackage

// File: rtl/irs_reset_qual.sv
module irs_reset_qual #(
  parameter int MIN_CYC = 4
) (
  input  logic clk,
  input  logic rst_in,
  output logic rst_active,
  output logic vec_load
);
  localparam int CW = $clog2(MIN_CYC + 1);
  localparam logic [CW-1:0] LIMIT = CW'(MIN_CYC);

  logic [CW-1:0] run_q;
  logic          vec_q;

  // Counts consecutive high edges and saturates at the limit.
  always_ff @(posedge clk) begin
    if (rst_in) begin
      run_q <= (run_q >= LIMIT) ? LIMIT : run_q + CW'(1);
    end else begin
      run_q <= '0;
    end
    vec_q <= rst_active && !rst_in;
  end

  assign rst_active = (run_q == LIMIT);
  assign vec_load   = vec_q;

endmodule

// File: rtl/irs_nmi_latch.sv
module irs_nmi_latch (
  input  logic clk,
  input  logic clr,
  input  logic nmi_in,
  input  logic consume,
  output logic nmi_rise,
  output logic nmi_pend,
  output logic nmi_now
);
  logic prev_q;
  logic pend_q;

  always_ff @(posedge clk) begin
    prev_q <= nmi_in;
    if (clr) begin
      pend_q <= 1'b0;
    end else if (consume) begin
      pend_q <= 1'b0;
    end else begin
      pend_q <= pend_q | nmi_rise;
    end
  end

  assign nmi_rise = nmi_in & ~prev_q;
  assign nmi_pend = pend_q;
  assign nmi_now  = pend_q | nmi_rise;

endmodule

// File: rtl/irs_arbiter.sv
module irs_arbiter
  import irs_pkg::*;
#(
  parameter int TYPE_W   = 8,
  parameter int NMI_TYPE = 2
) (
  input  logic              clk,
  input  logic              clr,
  input  logic              insn_end,
  input  logic              wait_op,
  input  logic              test_n,
  input  logic              intr_in,
  input  logic              ie_flag,
  input  logic              nmi_now,
  output logic              consume,
  output logic              take_irq,
  output logic [TYPE_W-1:0] irq_type,
  output logic              ack_req_n,
  output logic              waiting
);
  dec_e        sel;
  logic        serve;
  logic        take_q;
  logic        ack_n_q;
  logic        wait_q;
  logic [TYPE_W-1:0] type_q;

  always_comb begin
    serve = insn_end | wait_q;
    sel   = DEC_NONE;
    if (serve && nmi_now) begin
      sel = DEC_NMI;
    end else if (serve && intr_in && ie_flag) begin
      sel = DEC_ACK;
    end else if (wait_q && test_n) begin
      sel = DEC_WAIT;
    end else if (!wait_q && insn_end && wait_op && test_n) begin
      sel = DEC_WAIT;
    end
  end

  assign consume = (sel == DEC_NMI) && !clr;

  always_ff @(posedge clk) begin
    if (clr) begin
      take_q  <= 1'b0;
      type_q  <= '0;
      ack_n_q <= 1'b1;
      wait_q  <= 1'b0;
    end else begin
      take_q  <= (sel == DEC_NMI);
      type_q  <= (sel == DEC_NMI) ? TYPE_W'(NMI_TYPE) : '0;
      ack_n_q <= (sel != DEC_ACK);
      wait_q  <= (sel == DEC_WAIT);
    end
  end

  assign take_irq  = take_q;
  assign irq_type  = type_q;
  assign ack_req_n = ack_n_q;
  assign waiting   = wait_q;

endmodule

// File: rtl/irs_ctrl.sv
module irs_ctrl
  import irs_pkg::*;
#(
  parameter int         MIN_RST  = 4,
  parameter int         TYPE_W   = 8,
  parameter int         NMI_TYPE = 2,
  parameter logic [15:0] RST_SEG = 16'hFFFF,
  parameter logic [15:0] RST_OFF = 16'h0000
) (
  input  logic              clk,
  input  logic              rst_in,
  input  logic              nmi_in,
  input  logic              intr_in,
  input  logic              ie_flag,
  input  logic              test_n,
  input  logic              insn_end,
  input  logic              wait_op,
  output logic              take_irq,
  output logic [TYPE_W-1:0] irq_type,
  output logic              ack_req_n,
  output logic              stall,
  output logic              vec_load,
  output logic [19:0]       vec_addr
);
  // Internal events brought out by name for the checker.
  logic rst_active;
  logic nmi_rise;
  logic nmi_pend;
  logic nmi_now;
  logic consume;
  logic waiting;

  irs_reset_qual #(.MIN_CYC(MIN_RST)) u_rst (
    .clk        (clk),
    .rst_in     (rst_in),
    .rst_active (rst_active),
    .vec_load   (vec_load)
  );

  irs_nmi_latch u_nmi (
    .clk      (clk),
    .clr      (rst_active),
    .nmi_in   (nmi_in),
    .consume  (consume),
    .nmi_rise (nmi_rise),
    .nmi_pend (nmi_pend),
    .nmi_now  (nmi_now)
  );

  irs_arbiter #(.TYPE_W(TYPE_W), .NMI_TYPE(NMI_TYPE)) u_arb (
    .clk       (clk),
    .clr       (rst_active),
    .insn_end  (insn_end),
    .wait_op   (wait_op),
    .test_n    (test_n),
    .intr_in   (intr_in),
    .ie_flag   (ie_flag),
    .nmi_now   (nmi_now),
    .consume   (consume),
    .take_irq  (take_irq),
    .irq_type  (irq_type),
    .ack_req_n (ack_req_n),
    .waiting   (waiting)
  );

  assign stall    = waiting | rst_active;
  assign vec_addr = phys_addr(RST_SEG, RST_OFF);

endmodule

// File: rtl/irs_ctrl_chk.sv
module irs_ctrl_chk #(
  parameter int TYPE_W   = 8,
  parameter int NMI_TYPE = 2
) (
  input logic              clk,
  input logic              rst_in,
  input logic              rst_active,
  input logic              intr_in,
  input logic              ie_flag,
  input logic              test_n,
  input logic              nmi_pend,
  input logic              nmi_now,
  input logic              consume,
  input logic              waiting,
  input logic              take_irq,
  input logic [TYPE_W-1:0] irq_type,
  input logic              ack_req_n,
  input logic              vec_load
);
  // R1
  nmi_hold_chk: assert property (@(posedge clk) disable iff (rst_in || rst_active)
    (nmi_pend && !consume) |=> nmi_pend);

  // R2
  take_type_chk: assert property (@(posedge clk) disable iff (rst_in || rst_active)
    take_irq |-> (irq_type == TYPE_W'(NMI_TYPE)));

  // R3
  one_source_chk: assert property (@(posedge clk) disable iff (rst_in || rst_active)
    !(take_irq && !ack_req_n));

  // R4
  ack_gate_chk: assert property (@(posedge clk) disable iff (rst_in || rst_active)
    !ack_req_n |-> ($past(ie_flag) && $past(intr_in)));

  // R6
  wait_hold_chk: assert property (@(posedge clk) disable iff (rst_in || rst_active)
    (waiting && test_n && !nmi_now && !(intr_in && ie_flag)) |=> waiting);

  // R8
  vec_pulse_chk: assert property (@(posedge clk) disable iff (rst_in)
    vec_load |=> !vec_load);
endmodule

bind irs_ctrl irs_ctrl_chk #(.TYPE_W(TYPE_W), .NMI_TYPE(NMI_TYPE)) u_chk (
  .clk        (clk),
  .rst_in     (rst_in),
  .rst_active (rst_active),
  .intr_in    (intr_in),
  .ie_flag    (ie_flag),
  .test_n     (test_n),
  .nmi_pend   (nmi_pend),
  .nmi_now    (nmi_now),
  .consume    (consume),
  .waiting    (waiting),
  .take_irq   (take_irq),
  .irq_type   (irq_type),
  .ack_req_n  (ack_req_n),
  .vec_load   (vec_load)
);

// File: tb/irs_ctrl_test.sv
module irs_ctrl_test;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_in = 1'b1, nmi_in = 1'b0, intr_in = 1'b0, ie_flag = 1'b0;
  logic test_n = 1'b1, insn_end = 1'b0, wait_op = 1'b0;
  logic take_irq, ack_req_n, stall, vec_load;
  logic [7:0]  irq_type;
  logic [19:0] vec_addr;

  irs_ctrl uut (
    .clk(clk), .rst_in(rst_in), .nmi_in(nmi_in), .intr_in(intr_in),
    .ie_flag(ie_flag), .test_n(test_n), .insn_end(insn_end), .wait_op(wait_op),
    .take_irq(take_irq), .irq_type(irq_type), .ack_req_n(ack_req_n),
    .stall(stall), .vec_load(vec_load), .vec_addr(vec_addr)
  );

  int checks = 0;
  int errors = 0;
  bit cmp_on = 1'b0;
  bit done   = 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Behavioural reference model, one step per rising edge.
  int m_cnt  = 0;
  bit m_prev = 0, m_pend = 0, m_wait = 0;
  bit e_take = 0, e_ack = 1, e_vec = 0, e_stall = 0;
  int e_type = 0;
  bit rise, was_rst, pending, serve;

  always @(posedge clk) begin
    rise    = nmi_in && !m_prev;
    m_prev  = nmi_in;
    was_rst = (m_cnt == 4);
    e_vec   = was_rst && !rst_in;
    e_take  = 0; e_ack = 1; e_type = 0;
    if (was_rst) begin
      m_pend = 0; m_wait = 0;
    end else begin
      pending = m_pend || rise;
      serve   = m_wait || insn_end;
      if (serve && pending) begin
        e_take = 1; e_type = 2; m_pend = 0; m_wait = 0;
      end else if (serve && intr_in && ie_flag) begin
        e_ack = 0; m_wait = 0; m_pend = pending;
      end else begin
        m_pend = pending;
        if (m_wait) m_wait = test_n;
        else if (insn_end && wait_op && test_n) m_wait = 1;
      end
    end
    if (rst_in) m_cnt = (m_cnt < 4) ? m_cnt + 1 : 4;
    else        m_cnt = 0;
    e_stall = m_wait || (m_cnt == 4);
  end

  always @(negedge clk) begin
    if (cmp_on) begin
      chk("R2 take_irq vs model", take_irq, e_take);
      chk("R2 irq_type vs model", irq_type, e_type);
      chk("R4 ack_req_n vs model", ack_req_n, e_ack);
      chk("R6 stall vs model", stall, e_stall);
      chk("R8 vec_load vs model", vec_load, e_vec);
    end
  end

  task automatic tick();
    @(negedge clk);
  endtask

  initial begin
    // R8 qualified power-up reset
    repeat (5) tick();
    chk("R8 stall while reset held", stall, 1);
    rst_in = 0;
    tick();
    chk("R8 vec_load after release", vec_load, 1);
    chk("R8 vec_addr", vec_addr, 20'hFFFF0);
    cmp_on = 1;
    tick();
    chk("R8 vec_load one cycle", vec_load, 0);

    // R1 / R2 edge latch and service
    nmi_in = 1;
    tick(); tick();
    chk("R1 no take before boundary", take_irq, 0);
    ie_flag = 0;
    insn_end = 1;
    tick();
    chk("R2 take at boundary", take_irq, 1);
    chk("R2 type two", irq_type, 2);
    insn_end = 0;
    tick();
    chk("R2 take one cycle", take_irq, 0);
    insn_end = 1;
    tick();
    chk("R1 held level no retrigger", take_irq, 0);
    insn_end = 0; nmi_in = 0;
    tick();

    // R5 / R4 maskable request
    intr_in = 1; ie_flag = 0; insn_end = 1;
    tick();
    chk("R5 masked by flag", ack_req_n, 1);
    insn_end = 0; ie_flag = 1;
    tick();
    chk("R5 ignored off boundary", ack_req_n, 1);
    insn_end = 1;
    tick();
    chk("R4 ack low", ack_req_n, 0);
    chk("R4 type zero", irq_type, 0);
    insn_end = 0;
    tick();
    chk("R4 ack one cycle", ack_req_n, 1);

    // R3 priority
    nmi_in = 1; insn_end = 1;
    tick();
    chk("R3 nmi first", take_irq, 1);
    chk("R3 ack held off", ack_req_n, 1);
    tick();
    chk("R3 maskable next boundary", ack_req_n, 0);
    insn_end = 0; intr_in = 0; nmi_in = 0;
    tick();

    // R6 wait on test input
    wait_op = 1; test_n = 1; insn_end = 1;
    tick();
    chk("R6 stall on", stall, 1);
    insn_end = 0; wait_op = 0;
    repeat (3) tick();
    chk("R6 stall held", stall, 1);
    test_n = 0;
    tick();
    chk("R6 stall off", stall, 0);
    wait_op = 1; insn_end = 1;
    tick();
    chk("R6 test low no stall", stall, 0);
    insn_end = 0; wait_op = 0; test_n = 1;
    tick();

    // R7 interrupts end a wait
    wait_op = 1; insn_end = 1;
    tick();
    insn_end = 0; wait_op = 0;
    tick();
    nmi_in = 1;
    tick();
    chk("R7 nmi taken in wait", take_irq, 1);
    chk("R7 stall released", stall, 0);
    nmi_in = 0;
    tick();
    wait_op = 1; insn_end = 1;
    tick();
    insn_end = 0; wait_op = 0; intr_in = 1;
    tick();
    chk("R7 ack in wait", ack_req_n, 0);
    chk("R7 stall released by ack", stall, 0);
    intr_in = 0;
    tick();

    // R9 short reset pulse ignored
    nmi_in = 1;
    tick();
    nmi_in = 0; rst_in = 1;
    for (int i = 0; i < 3; i++) begin
      tick();
      chk("R9 no stall on short pulse", stall, 0);
    end
    rst_in = 0;
    tick();
    chk("R9 no vec_load", vec_load, 0);
    insn_end = 1;
    tick();
    chk("R9 pending nmi kept", take_irq, 1);
    insn_end = 0;
    tick();

    // R10 qualified reset clears wait and pending request
    wait_op = 1; insn_end = 1;
    tick();
    insn_end = 0; wait_op = 0;
    rst_in = 1;
    repeat (4) tick();
    chk("R10 stall in reset", stall, 1);
    rst_in = 0;
    tick();
    chk("R10 wait cleared", stall, 0);
    chk("R10 vec_load", vec_load, 1);
    nmi_in = 1;
    tick();
    nmi_in = 0; rst_in = 1;
    repeat (4) tick();
    rst_in = 0;
    tick();
    insn_end = 1;
    tick();
    chk("R10 pending nmi cleared", take_irq, 0);
    insn_end = 0;
    repeat (2) tick();

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule